// File: doc/BRIEF.md
# Synchronous Burst Memory with Wrapping Address Counter

This block is a clocked, flow-through static memory for use as local storage on a chip. Address, write data and all control inputs are sampled on the rising clock edge. A sampled read presents its word on the data output during the following cycle, straight from the array with no output register. The array is byte-lane organised, 1K words of 32 bits in four 8-bit lanes by default, and each lane can be written on its own.

An access begins on a cycle in which either of two active-low address strobes is low while all three chip enables are asserted. The block can then run a four-word burst. A 2-bit counter replaces the two low address bits, and an active-low step input advances it. The counter either adds to the starting low bits modulo 4 or XORs with them, depending on an order-select input. The burst is optional: a fresh address can be strobed on every cycle at full rate.

Writes are either global, covering every lane, or masked per lane. An output-enable input and a sleep input act without the clock. Sleep freezes the block and keeps the stored contents. The shared data bus is split into an input port, an output port and an output-valid flag.

Top module: `sync_burst_sram`

## Requirements
- R1: Inputs are sampled on the rising clock edge, and a read started at an edge drives its word on `dout`, with `dout_en` high, in the cycle right after that edge (flow-through).
- R2: An access starts when `strobe_a_n` or `strobe_b_n` is low at an edge, but only if `ce0_n` is low, `ce1` is high and `ce2_n` is low. The address is then taken from `addr`.
- R3: A strobe at an edge while the chip enables are not all asserted ends any running burst and leaves `dout_en` low. Later step requests do not restart the burst.
- R4: During a burst, `step_n` low at an edge moves to the next word of the four-word group. `step_n` high repeats the current word. Each following word takes one cycle, giving 2-1-1-1 read timing.
- R5: With `seq_order` = 0 (linear), the two low address bits of burst word k are (start low bits + k) mod 4. The upper address bits stay fixed, so the burst wraps inside its aligned 4-word group.
- R6: With `seq_order` = 1 (interleaved), the two low address bits of burst word k are the start low bits XOR k.
- R7: `all_wr_n` low during an access writes every lane, ignoring `byte_wr_n` and `lane_sel_n`.
- R8: With `all_wr_n` high and `byte_wr_n` low, only lanes i with `lane_sel_n[i]` low are written. Lane i is bits 8i+7..8i of `din`. With both write inputs high, the access is a read.
- R9: `dout_en` is high only when the last sampled access was a read, `oe_n` is low and `sleep_req` is low. `oe_n` acts at once, without waiting for a clock edge.
- R10: In the cycle after a write edge, `dout_en` is low.
- R11: While `sleep_req` is high, `dout_en` is low and every synchronous input is ignored. Stored words and the burst position are kept and take effect again when sleep ends.
- R12: A new address can be strobed on every cycle with no idle cycle between accesses.
- R13: After reset, no burst is running and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, taken at an access start |
| strobe_a_n | input | 1 | First address strobe, active low |
| strobe_b_n | input | 1 | Second address strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| seq_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| all_wr_n | input | 1 | Global write of every lane, active low |
| byte_wr_n | input | 1 | Lane-masked write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| din | input | LANES*8 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep, active high |
| dout | output | LANES*8 | Read data |
| dout_en | output | 1 | Read data valid / bus drive flag |

## Verification
The bench drives bursts that start from a middle word so that both counting orders have to wrap inside the aligned group. A design that carried into the upper address bits would return words from the next group. A design that mixed up the add and XOR orders would return them in the wrong sequence.

A partial-lane write is read back to check that unselected lanes keep their old bytes. A global write with no lanes selected must still write every lane, which catches a design where the lane selects override the global write.

A strobe with one chip enable deasserted must end the burst, so a later step must not bring data back. A write strobed during sleep must leave memory and the burst position untouched, which catches a design that lets sleep block only the output. Toggling the output enable between clock edges shows whether it was wrongly registered.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low address bits of the current burst word.
    function automatic logic [BURST_W-1:0] burst_lsb(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input burst_order_e       ord
    );
        logic [BURST_W-1:0] res;
        if (ord == ORD_INTERLEAVE) res = base ^ cnt;
        else                       res = base + cnt;
        return res;
    endfunction

endpackage

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              start_req,
    input  logic              selected,
    input  logic              step_n,
    input  burst_order_e      order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              access,
    output logic [ADDR_W-1:0] eff_addr
);

    logic                  burst_on;
    logic [ADDR_W-1:0]     base_addr;
    logic [BURST_W-1:0]    cnt;
    logic [BURST_W-1:0]    nxt_cnt;
    logic                  start, desel, cont;

    always_comb begin
        start   = !hold && start_req && selected;
        desel   = !hold && start_req && !selected;
        cont    = !hold && !start_req && burst_on;
        nxt_cnt = cnt + BURST_W'(cont && !step_n);
        access  = start || cont;
        if (start)
            eff_addr = addr_in;
        else
            eff_addr = {base_addr[ADDR_W-1:BURST_W],
                        burst_lsb(base_addr[BURST_W-1:0], nxt_cnt, order)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_on  <= 1'b0;
            base_addr <= '0;
            cnt       <= '0;
        end else if (start) begin
            burst_on  <= 1'b1;
            base_addr <= addr_in;
            cnt       <= '0;
        end else if (desel) begin
            burst_on  <= 1'b0;
        end else if (cont) begin
            cnt       <= nxt_cnt;
        end
    end

endmodule

// File: rtl/sbs_write_ctl.sv
module sbs_write_ctl #(
    parameter int LANES = 4
) (
    input  logic             access,
    input  logic             all_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic             wr_cycle,
    output logic [LANES-1:0] lane_we
);

    assign wr_cycle = access && (!all_wr_n || !byte_wr_n);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = access && (!all_wr_n || (!byte_wr_n && !lane_sel_n[g]));
    end

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                lane_mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              step_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              ce2_n,
    input  logic              seq_order,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    input  logic              sleep_req,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              access;
    logic              wr_cycle;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic              rd_q;
    logic              selected;

    assign selected = !ce0_n && ce1 && !ce2_n;

    sbs_addr_gen #(.ADDR_W(ADDR_W)) i_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .hold      (sleep_req),
        .start_req (!strobe_a_n || !strobe_b_n),
        .selected  (selected),
        .step_n    (step_n),
        .order     (burst_order_e'(seq_order)),
        .addr_in   (addr),
        .access    (access),
        .eff_addr  (eff_addr)
    );

    sbs_write_ctl #(.LANES(LANES)) i_write_ctl (
        .access     (access),
        .all_wr_n   (all_wr_n),
        .byte_wr_n  (byte_wr_n),
        .lane_sel_n (lane_sel_n),
        .wr_cycle   (wr_cycle),
        .lane_we    (lane_we)
    );

    sbs_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES)) i_mem (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (eff_addr),
        .wdata   (din),
        .rd_addr (cur_addr),
        .rdata   (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= 1'b0;
            cur_addr <= '0;
        end else if (!sleep_req) begin
            rd_q <= access && !wr_cycle;
            if (access) cur_addr <= eff_addr;
        end
    end

    assign dout_en = rd_q && !oe_n && !sleep_req;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_a_n,
    input logic              strobe_b_n,
    input logic              ce0_n,
    input logic              ce1,
    input logic              ce2_n,
    input logic              all_wr_n,
    input logic              byte_wr_n,
    input logic [LANES-1:0]  lane_sel_n,
    input logic              oe_n,
    input logic              sleep_req,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              access,
    input logic              wr_cycle,
    input logic [LANES-1:0]  lane_we
);

    // R9
    out_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sleep_req)) |->
        (dout_en == ($past(access && !wr_cycle) && !oe_n && !sleep_req)));

    // R10
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cycle |=> !dout_en);

    // R3
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        ((!strobe_a_n || !strobe_b_n) && !(!ce0_n && ce1 && !ce2_n) && !sleep_req)
        |=> !dout_en);

    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (lane_we == '0 && !dout_en));

    // R11
    sleep_data_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> $stable(dout));

    // R7
    global_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !all_wr_n) |-> (lane_we == {LANES{1'b1}}));

    // R8
    lane_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (access && all_wr_n && !byte_wr_n) |-> (lane_we == ~lane_sel_n));

endmodule

bind sync_burst_sram sbs_chk #(.LANES(LANES), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .ce0_n      (ce0_n),
    .ce1        (ce1),
    .ce2_n      (ce2_n),
    .all_wr_n   (all_wr_n),
    .byte_wr_n  (byte_wr_n),
    .lane_sel_n (lane_sel_n),
    .oe_n       (oe_n),
    .sleep_req  (sleep_req),
    .dout       (dout),
    .dout_en    (dout_en),
    .access     (access),
    .wr_cycle   (wr_cycle),
    .lane_we    (lane_we)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

    localparam int AW = 10;
    localparam int NL = 4;
    localparam int DW = NL * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          strobe_a_n, strobe_b_n, step_n;
    logic          ce0_n, ce1, ce2_n, seq_order;
    logic          all_wr_n, byte_wr_n;
    logic [NL-1:0] lane_sel_n;
    logic [DW-1:0] din;
    logic          oe_n, sleep_req;
    logic [DW-1:0] dout;
    logic          dout_en;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NL)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .addr(addr),
        .strobe_a_n(strobe_a_n), .strobe_b_n(strobe_b_n), .step_n(step_n),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .seq_order(seq_order),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
        .din(din), .oe_n(oe_n), .sleep_req(sleep_req),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        strobe_a_n = 1'b1; strobe_b_n = 1'b1; step_n = 1'b1;
        ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0;
        all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_sel_n = '1;
        oe_n = 1'b0; sleep_req = 1'b0;
    endtask

    task automatic wr_one(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic gw, input logic bw, input logic [NL-1:0] sel);
        strobe_a_n = 1'b0; addr = a; din = d;
        all_wr_n = gw; byte_wr_n = bw; lane_sel_n = sel;
        tick();
        check("R10 no drive after write", {31'd0, dout_en}, 32'd1 - 32'd1);
        idle();
    endtask

    task automatic rd_one(input logic [AW-1:0] a, input bit use_b);
        if (use_b) strobe_b_n = 1'b0; else strobe_a_n = 1'b0;
        addr = a;
        tick();
        strobe_a_n = 1'b1; strobe_b_n = 1'b1;
    endtask

    task automatic expect_word(input string req, input logic [DW-1:0] exp);
        check(req, dout, exp);
        check({req, " valid"}, {31'd0, dout_en}, 32'd1);
    endtask

    task automatic t_reset();
        check("R13 reset dout_en", {31'd0, dout_en}, 32'd0);
        rst = 1'b0;
        tick();
        check("R13 idle after reset", {31'd0, dout_en}, 32'd0);
    endtask

    task automatic t_fill();
        // R7 R12: global writes on back-to-back cycles
        for (int i = 0; i < 8; i++)
            wr_one(AW'(10'h040 + i), 32'hA000_0040 + i, 1'b0, 1'b1, 4'b1111);
    endtask

    task automatic t_single_reads();
        // R1 R2 R12: new address every cycle, alternating strobes
        strobe_b_n = 1'b0; addr = 10'h045; tick();
        expect_word("R1 first word", 32'hA000_0045);
        strobe_b_n = 1'b1; strobe_a_n = 1'b0; addr = 10'h041; tick();
        expect_word("R12 back-to-back A", 32'hA000_0041);
        strobe_a_n = 1'b1; strobe_b_n = 1'b0; addr = 10'h047; tick();
        expect_word("R2 strobe B", 32'hA000_0047);
        idle();
    endtask

    task automatic t_linear();
        seq_order = 1'b0;
        rd_one(10'h042, 1'b0);
        expect_word("R5 lin w0", 32'hA000_0042);
        step_n = 1'b0; tick(); expect_word("R5 lin w1", 32'hA000_0043);
        tick(); expect_word("R5 lin w2 wrap", 32'hA000_0040);
        tick(); expect_word("R4 lin w3", 32'hA000_0041);
        step_n = 1'b1; tick(); expect_word("R4 hold", 32'hA000_0041);
        step_n = 1'b0; tick(); expect_word("R4 counter wrap", 32'hA000_0042);
        idle();
    endtask

    task automatic t_interleave();
        seq_order = 1'b1;
        rd_one(10'h046, 1'b1);
        expect_word("R6 int w0", 32'hA000_0046);
        step_n = 1'b0; tick(); expect_word("R6 int w1", 32'hA000_0047);
        tick(); expect_word("R6 int w2", 32'hA000_0044);
        tick(); expect_word("R6 int w3", 32'hA000_0045);
        idle();
        seq_order = 1'b0;
    endtask

    task automatic t_lanes();
        // R8: lanes 0 and 2 only
        wr_one(10'h041, 32'h1122_3344, 1'b1, 1'b0, 4'b1010);
        rd_one(10'h041, 1'b0);
        expect_word("R8 masked lanes", 32'hA022_0044);
        // R7: global overrides empty lane select
        wr_one(10'h043, 32'h5566_7788, 1'b0, 1'b0, 4'b1111);
        rd_one(10'h043, 1'b0);
        expect_word("R7 global over lanes", 32'h5566_7788);
    endtask

    task automatic t_deselect();
        ce1 = 1'b0; strobe_a_n = 1'b0; addr = 10'h044; tick();
        check("R3 not selected", {31'd0, dout_en}, 32'd0);
        idle();
        rd_one(10'h044, 1'b0);
        expect_word("R2 selected read", 32'hA000_0044);
        ce0_n = 1'b1; strobe_b_n = 1'b0; tick();
        check("R3 deselect ends", {31'd0, dout_en}, 32'd0);
        idle(); step_n = 1'b0; tick();
        check("R3 no restart by step", {31'd0, dout_en}, 32'd0);
        idle();
    endtask

    task automatic t_oe();
        rd_one(10'h045, 1'b0);
        expect_word("R9 read", 32'hA000_0045);
        oe_n = 1'b1; #1;
        check("R9 oe off async", {31'd0, dout_en}, 32'd0);
        oe_n = 1'b0; #1;
        expect_word("R9 oe on async", 32'hA000_0045);
    endtask

    task automatic t_sleep();
        rd_one(10'h040, 1'b0);
        expect_word("R11 pre sleep", 32'hA000_0040);
        sleep_req = 1'b1; #1;
        check("R11 off in sleep", {31'd0, dout_en}, 32'd0);
        strobe_a_n = 1'b0; addr = 10'h047; din = 32'hDEAD_BEEF;
        all_wr_n = 1'b0; step_n = 1'b0;
        tick(); tick();
        idle(); #1;
        expect_word("R11 state kept", 32'hA000_0040);
        tick();
        expect_word("R11 burst kept", 32'hA000_0040);
        rd_one(10'h047, 1'b0);
        expect_word("R11 write ignored", 32'hA000_0047);
    endtask

    initial begin
        rst = 1'b1; addr = '0; din = '0; seq_order = 1'b0;
        idle();
        repeat (3) tick();
        t_reset();
        t_fill();
        t_single_reads();
        t_linear();
        t_interleave();
        t_lanes();
        t_deselect();
        t_oe();
        t_sleep();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule